// File: doc/BRIEF.md
# Borrow-Free Subtract Slice with Persistent Carry

This block is a 64-bit integer execution slice that performs subtraction by adding the complement of one operand to the other. It offers two operations. The plain form forces the carry-in to one, so it yields B minus A. The extended form takes its carry-in from a carry bit held in a status word. Both forms write their own carry-out back into that bit. Because the subtraction is an addition, the stored carry means "no borrow": it is 1 when B is at least A as unsigned values.

The carry persists between operations. A plain subtract of the two values to compare can therefore be followed by an extended subtract of its result from itself. The second operation returns all-ones when the first value was below the second, and zero otherwise. This gives a branchless unsigned less-than mask.

Results and the status word are registered. They appear on the clock edge that accepts a valid operation, and a one-cycle valid pulse marks them.

Top module: `sub_carry_slice`

## Requirements
- R1: With `op_valid` high and `op_ext` = 0, the next `res_word` is `opnd_b - opnd_a` modulo 2^64, computed as NOT(`opnd_a`) + `opnd_b` + 1.
- R2: After an accepted operation with `op_ext` = 0, the carry bit is 1 when `opnd_b` >= `opnd_a` as unsigned values and 0 otherwise (1 - 2 clears it; 2 - 1 and 1 - 1 set it).
- R3: With `op_valid` high and `op_ext` = 1, the next `res_word` is NOT(`opnd_a`) + `opnd_b` + CA, where CA is the carry bit before the edge. The new carry bit is the carry-out of that 64-bit addition.
- R4: An extended subtract with equal operands returns all-ones when CA was 0 and zero when CA was 1, and it leaves CA unchanged.
- R5: `res_valid` is high for exactly the one cycle that follows each cycle with `op_valid` high, and it is low otherwise.
- R6: In a cycle with `op_valid` low, `res_word` and `stat_word` keep their values.
- R7: `stat_word` holds the carry at bit index 29, counting from the least significant bit as 0. Every other bit of `stat_word` stays 0.
- R8: A synchronous active-high `rst` clears `res_word`, `res_valid` and `stat_word` to 0.
- R9: A plain subtract with `opnd_a` = y and `opnd_b` = x, followed on the next cycle by an extended subtract of its result from itself, gives all-ones when x < y (unsigned) and zero otherwise, including when x = y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; the operation is accepted on the rising edge |
| op_ext | input | 1 | 0 = plain subtract (carry-in 1), 1 = extended subtract (carry-in from CA) |
| opnd_a | input | 64 | Operand whose complement is added |
| opnd_b | input | 64 | Operand added directly |
| res_word | output | 64 | Registered result |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| stat_word | output | 64 | Status word, carry at bit 29 |

## Verification
Every result, the carry bit and the valid pulse are due on the same rising edge that accepts the operation, one cycle after the inputs are presented. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge, and it compares all three outputs on the following falling edge, so each comparison sees exactly one edge of work. The two-step mask needs a further cycle, because the extended subtract reads the carry written by the step before it. For this reason the mask check is taken one falling edge after the extended operation has been driven.

// File: rtl/csub_pkg.sv
package csub_pkg;
  localparam int unsigned CSUB_W      = 64;
  localparam int unsigned CSUB_LANE_W = 16;
  localparam int unsigned CSUB_CA_POS = 29;

  typedef enum logic {
    OP_SUBC = 1'b0,
    OP_SUBE = 1'b1
  } csub_op_e;
endpackage

// File: rtl/csub_adder.sv
// Complement-and-add datapath, split into ripple-linked lanes.
module csub_adder #(
  parameter int unsigned W      = 64,
  parameter int unsigned LANE_W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NLANE = W / LANE_W;

  logic [NLANE:0] chain;
  logic [W-1:0]   a_inv;

  assign a_inv    = ~a_i;
  assign chain[0] = cin_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W:0] lane_sum;
    assign lane_sum = {1'b0, a_inv[g*LANE_W +: LANE_W]}
                    + {1'b0, b_i[g*LANE_W +: LANE_W]}
                    + {{LANE_W{1'b0}}, chain[g]};
    assign sum_o[g*LANE_W +: LANE_W] = lane_sum[LANE_W-1:0];
    assign chain[g+1]                = lane_sum[LANE_W];
  end

  assign cout_o = chain[NLANE];
endmodule

// File: rtl/csub_status.sv
// Status word register; only the carry position is ever written.
module csub_status #(
  parameter int unsigned W      = 64,
  parameter int unsigned CA_POS = 29
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic         ca_i,
  output logic [W-1:0] stat_o,
  output logic         ca_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (wr_en_i) begin
      stat_q[CA_POS] <= ca_i;
    end
  end

  assign stat_o = stat_q;
  assign ca_o   = stat_q[CA_POS];
endmodule

// File: rtl/csub_result.sv
// Result register with one-cycle valid pulse.
module csub_result #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  logic [W-1:0] data_q;
  logic         vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        data_q <= data_i;
      end
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/sub_carry_slice.sv
module sub_carry_slice
  import csub_pkg::*;
#(
  parameter int unsigned W      = CSUB_W,
  parameter int unsigned LANE_W = CSUB_LANE_W,
  parameter int unsigned CA_POS = CSUB_CA_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic         op_ext,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res_word,
  output logic         res_valid,
  output logic [W-1:0] stat_word
);
  csub_op_e     op_kind;
  logic         ca_now;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;

  assign op_kind = csub_op_e'(op_ext);

  always_comb begin
    unique case (op_kind)
      OP_SUBC: cin = 1'b1;
      OP_SUBE: cin = ca_now;
      default: cin = 1'b1;
    endcase
  end

  csub_adder #(.W(W), .LANE_W(LANE_W)) u_add (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  csub_status #(.W(W), .CA_POS(CA_POS)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .wr_en_i(op_valid),
    .ca_i   (cout),
    .stat_o (stat_word),
    .ca_o   (ca_now)
  );

  csub_result #(.W(W)) u_res (
    .clk   (clk),
    .rst   (rst),
    .load_i(op_valid),
    .data_i(sum),
    .data_o(res_word),
    .vld_o (res_valid)
  );
endmodule

// File: rtl/sub_carry_slice_checker.sv
module sub_carry_slice_checker #(
  parameter int unsigned W      = 64,
  parameter int unsigned CA_POS = 29
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic         op_ext,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] res_word,
  input logic         res_valid,
  input logic [W-1:0] stat_word
);
  localparam logic [W-1:0] CA_MASK = {{(W-1){1'b0}}, 1'b1} << CA_POS;

  assert_plain_diff_R1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ext) |=> res_word == ($past(opnd_b) - $past(opnd_a)));

  assert_plain_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ext) |=> stat_word[CA_POS] == ($past(opnd_b) >= $past(opnd_a)));

  assert_self_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ext && opnd_a == opnd_b) |=>
      (res_word == {W{~$past(stat_word[CA_POS])}}) && $stable(stat_word));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_word) && $stable(stat_word));

  assert_stat_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_word & ~CA_MASK) == '0);

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (res_word == '0) && !res_valid && (stat_word == '0));
endmodule

bind sub_carry_slice sub_carry_slice_checker #(.W(W), .CA_POS(CA_POS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_ext   (op_ext),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .res_word (res_word),
  .res_valid(res_valid),
  .stat_word(stat_word)
);

// File: tb/sub_carry_slice_test.sv
`timescale 1ns/1ps
module sub_carry_slice_test;
  localparam int W = 64;
  localparam int CAP = 29;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         op_ext = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] res_word;
  logic         res_valid;
  logic [W-1:0] stat_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sub_carry_slice uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ext(op_ext),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_word(res_word), .res_valid(res_valid), .stat_word(stat_word)
  );

  // Behavioural reference: subtraction with explicit borrow.
  logic [W-1:0] m_res = '0;
  logic         m_vld = 1'b0;
  logic         m_ca  = 1'b0;
  int           m_kind = 0; // 0 idle, 1 plain, 2 extended

  always @(posedge clk) begin
    logic [W:0] wide;
    if (rst) begin
      m_res <= '0; m_vld <= 1'b0; m_ca <= 1'b0; m_kind <= 0;
    end else begin
      m_vld <= op_valid;
      if (!op_valid) begin
        m_kind <= 0;
      end else if (!op_ext) begin
        m_res  <= opnd_b - opnd_a;
        m_ca   <= (opnd_b >= opnd_a);
        m_kind <= 1;
      end else begin
        wide   = {1'b0, opnd_b} - {1'b0, opnd_a} - ((m_ca) ? 65'd0 : 65'd1);
        m_res  <= wide[W-1:0];
        m_ca   <= ~wide[W];
        m_kind <= 2;
      end
    end
  end

  task automatic check64(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    string rq;
    logic [W-1:0] exp_stat;
    rq = (m_kind == 1) ? "R1" : (m_kind == 2) ? "R3" : "R6";
    check64(rq, res_word, m_res);
    check64("R5", {63'd0, res_valid}, {63'd0, m_vld});
    exp_stat = '0;
    exp_stat[CAP] = m_ca;
    check64((m_kind == 1) ? "R2/R7" : "R7", stat_word, exp_stat);
  endtask

  task automatic step(input logic v, input logic e, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    compare_all();
    op_valid = v; op_ext = e; opnd_a = a; opnd_b = b;
  endtask

  task automatic mask_pair(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] d;
    d = x - y;
    step(1'b1, 1'b0, y, x);
    step(1'b1, 1'b1, d, d);
    step(1'b0, 1'b0, '0, '0);
    check64("R9", res_word, (x < y) ? ONES : '0);
    check64("R4", {63'd0, stat_word[CAP]}, {63'd0, (x >= y)});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs cleared during reset
    check64("R8", res_word, '0);
    check64("R8", {63'd0, res_valid}, '0);
    check64("R8", stat_word, '0);
    rst = 1'b0;

    // R2 examples: 2-1, 1-2, 1-1
    step(1'b1, 1'b0, 64'd1, 64'd2);
    step(1'b0, 1'b0, '0, '0);
    check64("R2", res_word, 64'd1);
    check64("R2", {63'd0, stat_word[CAP]}, 64'd1);
    step(1'b1, 1'b0, 64'd2, 64'd1);
    step(1'b0, 1'b0, '0, '0);
    check64("R1", res_word, ONES);
    check64("R2", {63'd0, stat_word[CAP]}, 64'd0);
    step(1'b1, 1'b0, 64'd1, 64'd1);
    step(1'b0, 1'b0, '0, '0);
    check64("R1", res_word, 64'd0);
    check64("R2", {63'd0, stat_word[CAP]}, 64'd1);

    // R6: idle cycles keep state
    step(1'b0, 1'b0, 64'd77, 64'd5);
    step(1'b0, 1'b0, 64'd9, 64'd3);

    // R9 corners
    mask_pair(64'd0, 64'd0);
    mask_pair(64'd0, ONES);
    mask_pair(ONES, 64'd0);
    mask_pair(ONES, ONES);
    mask_pair(64'd5, 64'd6);
    mask_pair(64'd6, 64'd5);
    mask_pair(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    mask_pair(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);

    // Random mask pairs, some with equal or adjacent operands
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 7 == 0) y = x;
      if (i % 11 == 0) y = x + 1;
      mask_pair(x, y);
    end

    // R3: extended subtract with unrelated operands, back to back
    for (int i = 0; i < 200; i++) begin
      step(1'b1, ($urandom % 2) == 1, {$urandom, $urandom}, {$urandom, $urandom});
    end
    // R3 edge: carry-in 0 with zero operands gives all-ones and no carry
    step(1'b1, 1'b0, 64'd1, 64'd0);
    step(1'b1, 1'b1, 64'd0, 64'd0);
    step(1'b0, 1'b0, '0, '0);
    check64("R3", res_word, ONES);
    check64("R3", {63'd0, stat_word[CAP]}, 64'd0);

    // R8: reset mid-run
    step(1'b1, 1'b0, 64'd0, 64'd9);
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    @(negedge clk);
    check64("R8", res_word, '0);
    check64("R8", stat_word, '0);
    rst = 1'b0;
    step(1'b0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule